// File: doc/BRIEF.md
# Bit-Serial Scaling Adder Tree

This block reduces sixteen bit-serial product streams to one serial result. Every input carries a two's complement word of `WORD_BITS` bits, least significant bit first. All sixteen streams are aligned to one shared strobe, which is high on the bit time of each word's LSB. Words follow each other with no gap, so the strobe repeats every `WORD_BITS` cycles.

Four levels of two-input serial adders form a binary tree. Each adder clears its carry on its own word-start bit and registers its sum bit. The three inner levels halve each partial sum by re-framing it: the arriving LSB is dropped, the next bit becomes the new LSB, and the sign bit is repeated into the vacated top position. The root sum is not halved at that point. It is instead divided by four, with two sign repeats, and then registered onto the output. The strobe is delayed alongside the data, so the output strobe marks the bit time that carries the result's LSB. The result feeds a gain scaling stage downstream.

Top module: `bit_serial_adder_tree`

## Requirements
- R1: While `rst` is high, and on every cycle after it until the first input strobe has passed through the tree, `sum_bit` and `sum_lsb` are 0.
- R2: `sum_lsb` is high exactly LATENCY = 2*LEVELS + FINAL_SHIFT = 10 cycles after each cycle in which `prod_lsb` is high. Here LEVELS is log2 of NUM_IN. The output word's bit 0 appears on that cycle and its remaining bits follow, one per cycle.
- R3: Input `prod_bits[k]` carries bit k of the products. The first-level adders sum the streams in pairs 2j and 2j+1, then the pairs of those results, and so on. Each adder works modulo 2^WORD_BITS and clears its carry at the start of every word, so no carry passes from one word into the next.
- R4: Each adder result on the three inner levels is divided by two by an arithmetic right shift (rounding toward minus infinity) before it enters the next level.
- R5: The root adder result is not halved. It is arithmetically shifted right by FINAL_SHIFT = 2, so the top three bits of every output word are equal.
- R6: When every input word lies in the signed range of WORD_BITS-1 bits, no level overflows. All inputs at the positive limit 2^(WORD_BITS-2)-1 give 2^(WORD_BITS-3)-1, and all inputs at -2^(WORD_BITS-2) give -2^(WORD_BITS-3).
- R7: A single nonzero input v, with all other inputs at zero, produces v arithmetically shifted right by 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_bits | input | NUM_IN | One serial product bit per input stream, LSB first |
| prod_lsb | input | 1 | High on the LSB bit time of the input words |
| sum_bit | output | 1 | Serial scaled sum, LSB first, registered |
| sum_lsb | output | 1 | High on the bit time that carries the result's LSB |

## Verification
A stuck or leaking carry corrupts the word in which it happens and also the following word. The error shows up as a wrong value within two output words. A strobe delay that is off by one cycle in any level misframes every word. The output strobe then falls off its fixed 10-cycle distance from the input strobe, or the sign-fill pattern in the top bits breaks, on the very first word. A wrong hold of the sign bit in a rescaler is visible only on negative or wrapped sums, which is why directed extremes are mixed into the random words.

// File: rtl/bst_pkg.sv
package bst_pkg;

  // Cycles from an input strobe to the matching output strobe:
  // one register per adder level, one re-frame per inner level,
  // plus the final shift and the output register.
  function automatic int tree_latency(input int levels, input int final_shift);
    return levels + (levels - 1) + final_shift + 1;
  endfunction

endpackage

// File: rtl/bst_delay.sv
module bst_delay #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [DEPTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < DEPTH; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[DEPTH-1];

endmodule

// File: rtl/bst_serial_add.sv
module bst_serial_add (
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  input  logic first,
  output logic sum_q
);

  logic carry_q;
  logic cin;

  // The carry is dropped on the word's first bit, so words stay independent.
  assign cin = first ? 1'b0 : carry_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      sum_q   <= a ^ b ^ cin;
      carry_q <= (a & b) | (a & cin) | (b & cin);
    end
  end

endmodule

// File: rtl/bst_rescale.sv
module bst_rescale #(
  parameter int SHIFT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic old_lsb,
  output logic q
);

  logic fill;
  logic sign_hold;

  // The SHIFT bit times that start at the old word boundary carry dropped
  // low bits. They are replaced by the sign of the word before them.
  if (SHIFT == 1) begin : g_single
    assign fill = old_lsb;
  end else begin : g_multi
    logic [SHIFT-2:0] lsb_hist;
    always_ff @(posedge clk) begin
      if (rst) begin
        lsb_hist <= '0;
      end else begin
        lsb_hist[0] <= old_lsb;
        for (int i = 1; i < SHIFT - 1; i++) begin
          lsb_hist[i] <= lsb_hist[i-1];
        end
      end
    end
    assign fill = old_lsb | (|lsb_hist);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sign_hold <= 1'b0;
    end else if (!fill) begin
      sign_hold <= d;
    end
  end

  assign q = fill ? sign_hold : d;

endmodule

// File: rtl/bit_serial_adder_tree.sv
module bit_serial_adder_tree
  import bst_pkg::*;
#(
  parameter int NUM_IN      = 16,
  parameter int WORD_BITS   = 12,
  parameter int FINAL_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] prod_bits,
  input  logic              prod_lsb,
  output logic              sum_bit,
  output logic              sum_lsb
);

  localparam int LEVELS  = $clog2(NUM_IN);
  localparam int LATENCY = tree_latency(LEVELS, FINAL_SHIFT);

  if (NUM_IN != (1 << LEVELS) || LEVELS < 2) begin : g_bad_inputs
    $error("NUM_IN must be a power of two of at least 4");
  end
  if (WORD_BITS < FINAL_SHIFT + 2) begin : g_bad_word
    $error("WORD_BITS too short for the final shift");
  end

  // Heap numbering: node 1 is the root, node i has children 2i and 2i+1,
  // leaves NUM_IN..2*NUM_IN-1 are the inputs.
  logic [2*NUM_IN-1:1] node_bit;
  logic [NUM_IN-1:1]   node_sum;

  // st_lvl[d]: word-start strobe of the streams leaving depth d
  // add_st[d]: strobe of the registered adder sums at depth d
  logic [LEVELS:1]   st_lvl;
  logic [LEVELS-1:0] add_st;
  logic              scaled;

  assign st_lvl[LEVELS] = prod_lsb;

  for (genvar k = 0; k < NUM_IN; k++) begin : g_leaf
    assign node_bit[NUM_IN+k] = prod_bits[k];
  end

  for (genvar d = 0; d < LEVELS; d++) begin : g_lvl
    bst_delay #(.DEPTH(1)) u_add_st (
      .clk (clk),
      .rst (rst),
      .d   (st_lvl[d+1]),
      .q   (add_st[d])
    );

    if (d > 0) begin : g_half_st
      bst_delay #(.DEPTH(1)) u_half_st (
        .clk (clk),
        .rst (rst),
        .d   (add_st[d]),
        .q   (st_lvl[d])
      );
    end

    for (genvar j = 0; j < (1 << d); j++) begin : g_node
      localparam int IDX = (1 << d) + j;

      bst_serial_add u_add (
        .clk   (clk),
        .rst   (rst),
        .a     (node_bit[2*IDX]),
        .b     (node_bit[2*IDX+1]),
        .first (st_lvl[d+1]),
        .sum_q (node_sum[IDX])
      );

      if (d > 0) begin : g_half
        bst_rescale #(.SHIFT(1)) u_half (
          .clk     (clk),
          .rst     (rst),
          .d       (node_sum[IDX]),
          .old_lsb (add_st[d]),
          .q       (node_bit[IDX])
        );
      end else begin : g_root
        assign node_bit[IDX] = node_sum[IDX];
      end
    end
  end

  bst_rescale #(.SHIFT(FINAL_SHIFT)) u_final (
    .clk     (clk),
    .rst     (rst),
    .d       (node_bit[1]),
    .old_lsb (add_st[0]),
    .q       (scaled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_bit <= 1'b0;
    end else begin
      sum_bit <= scaled;
    end
  end

  bst_delay #(.DEPTH(FINAL_SHIFT + 1)) u_out_st (
    .clk (clk),
    .rst (rst),
    .d   (add_st[0]),
    .q   (sum_lsb)
  );

endmodule

// File: rtl/bst_checker.sv
module bst_checker #(
  parameter int NUM_IN  = 16,
  parameter int LEVELS  = 4,
  parameter int LATENCY = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              prod_lsb,
  input logic              sum_bit,
  input logic              sum_lsb,
  input logic [NUM_IN-1:2] inner_bit,
  input logic [LEVELS-1:1] inner_st
);

  logic [LATENCY-1:0] lsb_trail;

  always_ff @(posedge clk) begin
    if (rst) begin
      lsb_trail <= '0;
    end else begin
      lsb_trail[0] <= prod_lsb;
      for (int i = 1; i < LATENCY; i++) begin
        lsb_trail[i] <= lsb_trail[i-1];
      end
    end
  end

  // R1
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!sum_lsb && !sum_bit));

  // R2
  assert_strobe_latency_R2: assert property (@(posedge clk) disable iff (rst)
    sum_lsb == lsb_trail[LATENCY-1]);

  // R5: the two bits before a new output word repeat the sign bit
  assert_final_sign_fill_R5: assert property (@(posedge clk) disable iff (rst)
    sum_lsb |-> ($past(sum_bit, 1) == $past(sum_bit, 2) &&
                 $past(sum_bit, 2) == $past(sum_bit, 3)));

  // R4: each halved partial sum repeats its sign into the top bit
  for (genvar i = 2; i < NUM_IN; i++) begin : g_inner
    localparam int D = $clog2(i + 1) - 1;
    assert_half_sign_fill_R4: assert property (@(posedge clk) disable iff (rst)
      inner_st[D] |-> ($past(inner_bit[i], 1) == $past(inner_bit[i], 2)));
  end

endmodule

bind bit_serial_adder_tree bst_checker #(
  .NUM_IN  (NUM_IN),
  .LEVELS  (LEVELS),
  .LATENCY (LATENCY)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .prod_lsb  (prod_lsb),
  .sum_bit   (sum_bit),
  .sum_lsb   (sum_lsb),
  .inner_bit (node_bit[NUM_IN-1:2]),
  .inner_st  (st_lvl[LEVELS-1:1])
);

// File: tb/bit_serial_adder_tree_tb.sv
module bit_serial_adder_tree_tb_top;

  localparam int NI   = 16;
  localparam int NB   = 12;
  localparam int LAT  = 10;
  localparam int MAXV = 260;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NI-1:0] prod_bits = '0;
  logic          prod_lsb = 1'b0;
  logic          sum_bit;
  logic          sum_lsb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int    vecs [MAXV][NI];
  string tags [MAXV];
  int    nvec = 0;
  int    in_st_cycle [MAXV];

  always #2 clk = ~clk;

  bit_serial_adder_tree #(.NUM_IN(NI), .WORD_BITS(NB), .FINAL_SHIFT(2)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .prod_bits (prod_bits),
    .prod_lsb  (prod_lsb),
    .sum_bit   (sum_bit),
    .sum_lsb   (sum_lsb)
  );

  function automatic int wrapn(input int v);
    int m;
    m = v & ((1 << NB) - 1);
    if (m >= (1 << (NB - 1))) m -= (1 << NB);
    return m;
  endfunction

  // Stage-by-stage model: pairwise modulo sums, halve inner levels, root >>> 2
  function automatic int expect_word(input int vi);
    int cur [NI];
    int width;
    int s;
    for (int k = 0; k < NI; k++) cur[k] = vecs[vi][k];
    width = NI;
    while (width > 1) begin
      for (int j = 0; j < width / 2; j++) begin
        s = wrapn(cur[2*j] + cur[2*j+1]);
        if (width > 2) s = s >>> 1;
        cur[j] = s;
      end
      width = width / 2;
    end
    return cur[0] >>> 2;
  endfunction

  task automatic add_vec(input string tg, input int fillv);
    for (int k = 0; k < NI; k++) vecs[nvec][k] = fillv;
    tags[nvec] = tg;
    nvec++;
  endtask

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    int hi;
    int lo;
    void'($urandom(32'h5EED_0017));
    hi = (1 << (NB - 2)) - 1;
    lo = -(1 << (NB - 2));

    add_vec("R6 zero", 0);
    add_vec("R6 R5 all max", hi);
    add_vec("R6 R5 all min", lo);
    add_vec("R7 impulse pos", 0);
    vecs[nvec-1][5] = 1000;
    add_vec("R7 impulse neg", 0);
    vecs[nvec-1][10] = -1000;
    add_vec("R3 wrap pair", 0);
    vecs[nvec-1][0] = 2047;
    vecs[nvec-1][1] = 2047;
    add_vec("R3 carry leak neg", -1);
    add_vec("R3 carry leak pos", 1);
    add_vec("R3 pairing", 0);
    vecs[nvec-1][2] = 700;
    vecs[nvec-1][3] = -5;
    for (int i = 0; i < 150; i++) begin
      add_vec("R4 R6 random", 0);
      for (int k = 0; k < NI; k++)
        vecs[nvec-1][k] = int'($urandom_range(0, (1 << (NB - 1)) - 1)) + lo;
    end
    for (int i = 0; i < 50; i++) begin
      add_vec("R3 R4 random full", 0);
      for (int k = 0; k < NI; k++)
        vecs[nvec-1][k] = wrapn(int'($urandom_range(0, (1 << NB) - 1)));
    end
    add_vec("flush", 0);

    // R1: outputs quiet in reset and while idle afterwards
    repeat (4) begin
      @(negedge clk);
      check("R1 in reset", sum_bit == 1'b0 && sum_lsb == 1'b0, {sum_lsb, sum_bit}, 0);
    end
    rst = 1'b0;
    repeat (6) begin
      @(negedge clk);
      check("R1 idle", sum_bit == 1'b0 && sum_lsb == 1'b0, {sum_lsb, sum_bit}, 0);
    end

    begin
      int  total;
      int  out_idx;
      int  bitpos;
      bit  collecting;
      logic [NB-1:0] acc;
      int  v;
      int  b;
      int  got;
      int  exp;
      total      = nvec * NB + LAT + 2 * NB;
      out_idx    = 0;
      bitpos     = 0;
      collecting = 1'b0;
      acc        = '0;
      for (int c = 0; c < total; c++) begin
        @(negedge clk);
        // sample outputs
        if (sum_lsb) begin
          if (out_idx < nvec - 1) begin
            check("R2 strobe latency", c == in_st_cycle[out_idx] + LAT,
                  c, in_st_cycle[out_idx] + LAT);
          end
          collecting = 1'b1;
          bitpos = 0;
        end
        if (collecting) begin
          acc[bitpos] = sum_bit;
          if (bitpos == NB - 1) begin
            collecting = 1'b0;
            if (out_idx < nvec - 1) begin
              got = wrapn(int'(acc));
              exp = expect_word(out_idx);
              check(tags[out_idx], got == exp, got, exp);
              check("R5 top bits equal", acc[NB-1] == acc[NB-2] && acc[NB-2] == acc[NB-3],
                    int'(acc[NB-1:NB-3]), acc[NB-1] ? 7 : 0);
            end
            out_idx++;
          end
          bitpos++;
        end
        // drive inputs for this cycle
        v = c / NB;
        b = c % NB;
        if (v < nvec) begin
          for (int k = 0; k < NI; k++) prod_bits[k] = vecs[v][k][b];
          prod_lsb = (b == 0);
          if (b == 0) in_st_cycle[v] = c;
        end else begin
          prod_bits = '0;
          prod_lsb  = 1'b0;
        end
      end
      check("R2 word count", out_idx >= nvec - 1, out_idx, nvec - 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule